// File: doc/BRIEF.md
# Serial Character Link with Selectable Parity

This block sends and receives serial characters over a pair of single-wire lines. Each character is framed with a low start bit, the data bits least significant first, an optional parity bit and a high stop bit. The line rests high between frames. A 3-bit mode input selects the parity rule. Two rules follow the count of ones in the data (even, odd). Two force a constant bit (mark = 1, space = 0). The last setting drops the parity bit from the frame altogether.

The transmitter takes a character on a one-cycle valid strobe whenever it is idle. It computes the parity bit from the mode sampled at that moment. The receiver oversamples the line at 16 times the bit rate. It confirms a start bit half a bit after the falling edge, samples every later bit at its centre, and compares the received parity bit with the bit the mode predicts. Both sides lock the mode at the start of a frame. A parity mismatch produces a per-character error bit and also sets a status flag. That flag stays high until a reset-status command pulse clears it.

Top module: `uart_parity_link`

## Requirements
- R1: A transmitted frame is a 0 start bit, DATA_W data bits sent least significant bit first, the parity bit when parity is on, then a 1 stop bit. Every bit lasts 16*CLKS_PER_TICK clock cycles. The line is 1 whenever the transmitter is idle, and `tx_busy_o` is high from the cycle after acceptance until the end of the stop bit.
- R2: Mode 3'b000 (even): the parity bit is 0 when the data holds an even count of ones and 1 otherwise. The receiver flags a mismatch.
- R3: Mode 3'b001 (odd): the parity bit is 1 when the data holds an even count of ones and 0 otherwise. The receiver flags a mismatch.
- R4: Mode 3'b011 (mark): the parity bit is always sent as 1. A received parity bit of 0 is an error.
- R5: Mode 3'b010 (space): the parity bit is always sent as 0. A received parity bit of 1 is an error.
- R6: Mode 3'b1xx (none): no parity bit is sent or expected, the stop bit follows the last data bit, and `rx_par_err_o` is never raised.
- R7: A received character with a parity error sets `stat_par_err_o` one cycle after its `rx_valid_o` pulse. The flag then holds through later error-free characters until a `cmd_rst_stat_i` pulse clears it one cycle later.
- R8: When a new parity error and `cmd_rst_stat_i` meet in the same cycle, the flag is set (the error wins).
- R9: A change of `mode_i` after a frame has started does not affect that frame on either side. The transmitter uses the mode present at acceptance, and the receiver uses the mode present when it confirms the start bit.
- R10: The receiver delivers each character on `rx_data_o` with a one-cycle `rx_valid_o` pulse near the centre of the stop bit. `rx_par_err_o` is valid in that same cycle.
- R11: `tx_valid_i` is ignored while the transmitter is busy: the frame in flight is unchanged and no second frame follows.
- R12: After reset, `tx_o` is 1, `tx_busy_o` is 0, `rx_valid_o` is 0 and `stat_par_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Parity rule: 000 even, 001 odd, 010 space, 011 mark, 1xx none |
| tx_data_i | input | DATA_W | Character to send |
| tx_valid_i | input | 1 | Send strobe, taken only when idle |
| tx_busy_o | output | 1 | Transmitter is sending a frame |
| tx_o | output | 1 | Serial transmit line |
| rx_i | input | 1 | Serial receive line |
| rx_data_o | output | DATA_W | Last received character |
| rx_valid_o | output | 1 | One-cycle pulse: new character on rx_data_o |
| rx_par_err_o | output | 1 | Parity mismatch for the character in this cycle |
| stat_par_err_o | output | 1 | Sticky parity error flag |
| cmd_rst_stat_i | input | 1 | Pulse that clears the sticky flag |

## Verification
The transmit line goes low one cycle after the accepting edge. Each bit then holds for 16*CLKS_PER_TICK cycles, so the bench counts from the accepting edge and samples every bit at its centre. That leaves half a bit of margin on each side of each sample. Receiver delivery lands near the stop-bit centre, but the oversampling tick and the two-stage line synchronizer add a few cycles of variation, so the bench polls for the `rx_valid_o` pulse within one bit time of driving the stop bit. The sticky flag is checked one cycle after that pulse, and a clear is checked one cycle after the command.

// File: rtl/uart_par_pkg.sv
package uart_par_pkg;

    localparam int OSR = 16;

    localparam logic [1:0] PR_EVEN  = 2'b00;
    localparam logic [1:0] PR_ODD   = 2'b01;
    localparam logic [1:0] PR_SPACE = 2'b10;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
    } tx_st_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_CHECK, RX_DATA, RX_PAR, RX_STOP
    } rx_st_e;

    // Parity slot is present unless the top mode bit is set.
    function automatic logic par_used(input logic [2:0] m);
        return ~m[2];
    endfunction

    // Parity bit owed for a character under rule m (data zero-extended).
    function automatic logic par_value(input logic [2:0] m, input logic [31:0] d);
        case (m[1:0])
            PR_EVEN:  return ^d;
            PR_ODD:   return ~(^d);
            PR_SPACE: return 1'b0;
            default:  return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/uart_os_tick.sv
module uart_os_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);

            typedef struct packed {
                logic [CW-1:0] cnt;
                logic          tick;
            } tk_t;

            tk_t q, d;

            always_comb begin
                d = q;
                if (q.cnt == CW'(DIV - 1)) begin
                    d.cnt  = '0;
                    d.tick = 1'b1;
                end else begin
                    d.cnt  = q.cnt + 1'b1;
                    d.tick = 1'b0;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= d;
            end

            assign tick_o = q.tick;
        end
    endgenerate
endmodule

// File: rtl/uart_par_tx.sv
module uart_par_tx
    import uart_par_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int CLKS_PER_TICK = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              valid_i,
    output logic              tx_o,
    output logic              busy_o
);
    localparam int BIT_CLKS = OSR * CLKS_PER_TICK;
    localparam int CNT_W    = $clog2(BIT_CLKS);
    localparam int IDX_W    = $clog2(DATA_W);

    typedef struct packed {
        tx_st_e            st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] sh;
        logic              use_par;
        logic              par;
        logic              line;
    } tx_reg_t;

    tx_reg_t q, d;

    always_comb begin
        d = q;
        if (q.st == TX_IDLE) begin
            d.line = 1'b1;
            if (valid_i) begin
                d.st      = TX_START;
                d.cnt     = '0;
                d.sh      = data_i;
                d.use_par = par_used(mode_i);
                d.par     = par_value(mode_i, 32'(data_i));
                d.line    = 1'b0;
            end
        end else if (q.cnt == CNT_W'(BIT_CLKS - 1)) begin
            d.cnt = '0;
            case (q.st)
                TX_START: begin
                    d.st   = TX_DATA;
                    d.idx  = '0;
                    d.line = q.sh[0];
                end
                TX_DATA: begin
                    if (q.idx == IDX_W'(DATA_W - 1)) begin
                        if (q.use_par) begin
                            d.st   = TX_PAR;
                            d.line = q.par;
                        end else begin
                            d.st   = TX_STOP;
                            d.line = 1'b1;
                        end
                    end else begin
                        d.idx  = q.idx + 1'b1;
                        d.sh   = q.sh >> 1;
                        d.line = q.sh[1];
                    end
                end
                TX_PAR: begin
                    d.st   = TX_STOP;
                    d.line = 1'b1;
                end
                default: begin
                    d.st   = TX_IDLE;
                    d.line = 1'b1;
                end
            endcase
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= TX_IDLE;
            q.line <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tx_o   = q.line;
    assign busy_o = (q.st != TX_IDLE);
endmodule

// File: rtl/uart_par_rx.sv
module uart_par_rx
    import uart_par_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [2:0]        mode_i,
    input  logic              rx_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              err_o
);
    localparam int TK_W  = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [TK_W-1:0] MID  = TK_W'(OSR / 2 - 1);
    localparam logic [TK_W-1:0] LAST = TK_W'(OSR - 1);

    typedef struct packed {
        rx_st_e            st;
        logic [1:0]        sync;
        logic [TK_W-1:0]   cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] sh;
        logic [2:0]        mode;
        logic              perr;
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              err;
    } rx_reg_t;

    rx_reg_t q, d;
    logic    line;

    assign line = q.sync[1];

    always_comb begin
        d       = q;
        d.sync  = {q.sync[0], rx_i};
        d.valid = 1'b0;
        d.err   = 1'b0;
        if (tick_i) begin
            case (q.st)
                RX_IDLE: begin
                    if (!line) begin
                        d.st  = RX_CHECK;
                        d.cnt = '0;
                    end
                end
                RX_CHECK: begin
                    if (q.cnt == MID) begin
                        d.cnt = '0;
                        if (!line) begin
                            d.st   = RX_DATA;
                            d.idx  = '0;
                            d.mode = mode_i;
                            d.perr = 1'b0;
                        end else begin
                            d.st = RX_IDLE;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (q.cnt == LAST) begin
                        d.cnt = '0;
                        d.sh  = {line, q.sh[DATA_W-1:1]};
                        if (q.idx == IDX_W'(DATA_W - 1))
                            d.st = par_used(q.mode) ? RX_PAR : RX_STOP;
                        else
                            d.idx = q.idx + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (q.cnt == LAST) begin
                        d.cnt  = '0;
                        d.perr = (line != par_value(q.mode, 32'(q.sh)));
                        d.st   = RX_STOP;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: begin
                    if (q.cnt == LAST) begin
                        d.cnt   = '0;
                        d.data  = q.sh;
                        d.valid = 1'b1;
                        d.err   = q.perr;
                        d.st    = RX_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= RX_IDLE;
            q.sync <= 2'b11;
        end else begin
            q <= d;
        end
    end

    assign data_o  = q.data;
    assign valid_o = q.valid;
    assign err_o   = q.err;
endmodule

// File: rtl/uart_parity_link.sv
module uart_parity_link
    import uart_par_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int CLKS_PER_TICK = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_busy_o,
    output logic              tx_o,
    input  logic              rx_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              rx_par_err_o,
    output logic              stat_par_err_o,
    input  logic              cmd_rst_stat_i
);
    logic tick;
    logic stat_d, stat_q;

    uart_os_tick #(.DIV(CLKS_PER_TICK)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    uart_par_tx #(.DATA_W(DATA_W), .CLKS_PER_TICK(CLKS_PER_TICK)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_i),
        .data_i  (tx_data_i),
        .valid_i (tx_valid_i),
        .tx_o    (tx_o),
        .busy_o  (tx_busy_o)
    );

    uart_par_rx #(.DATA_W(DATA_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .mode_i  (mode_i),
        .rx_i    (rx_i),
        .data_o  (rx_data_o),
        .valid_o (rx_valid_o),
        .err_o   (rx_par_err_o)
    );

    // Sticky flag: a fresh error outranks the clear command.
    always_comb begin
        stat_d = stat_q;
        if (rx_valid_o && rx_par_err_o) stat_d = 1'b1;
        else if (cmd_rst_stat_i)        stat_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= 1'b0;
        else        stat_q <= stat_d;
    end

    assign stat_par_err_o = stat_q;
endmodule

// File: rtl/uart_parity_link_chk.sv
module uart_parity_link_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_o,
    input logic tx_busy_o,
    input logic rx_valid_o,
    input logic rx_par_err_o,
    input logic stat_par_err_o,
    input logic cmd_rst_stat_i
);
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy_o |-> tx_o);

    a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy_o) |-> !tx_o);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    a_r10_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rx_par_err_o |-> rx_valid_o);

    a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_o && rx_par_err_o) |=> stat_par_err_o);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_par_err_o && !cmd_rst_stat_i) |=> stat_par_err_o);

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rst_stat_i && !(rx_valid_o && rx_par_err_o)) |=> !stat_par_err_o);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rst_stat_i && rx_valid_o && rx_par_err_o) |=> stat_par_err_o);
endmodule

bind uart_parity_link uart_parity_link_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tx_o           (tx_o),
    .tx_busy_o      (tx_busy_o),
    .rx_valid_o     (rx_valid_o),
    .rx_par_err_o   (rx_par_err_o),
    .stat_par_err_o (stat_par_err_o),
    .cmd_rst_stat_i (cmd_rst_stat_i)
);

// File: tb/sim_uart_parity_link.sv
module sim_uart_parity_link;
    localparam int CLK_PERIOD = 10;
    localparam int CPT        = 2;
    localparam int BIT        = 16 * CPT;
    localparam int WD_CYCLES  = 150000;

    localparam logic [2:0] M_EVEN  = 3'b000;
    localparam logic [2:0] M_ODD   = 3'b001;
    localparam logic [2:0] M_SPACE = 3'b010;
    localparam logic [2:0] M_MARK  = 3'b011;
    localparam logic [2:0] M_NONE  = 3'b100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_i = M_EVEN;
    logic [7:0] tx_data_i = '0;
    logic       tx_valid_i = 1'b0;
    logic       tx_busy_o, tx_o;
    logic       rx_i = 1'b1;
    logic [7:0] rx_data_o;
    logic       rx_valid_o, rx_par_err_o, stat_par_err_o;
    logic       cmd_rst_stat_i = 1'b0;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_parity_link #(.DATA_W(8), .CLKS_PER_TICK(CPT)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_i         (mode_i),
        .tx_data_i      (tx_data_i),
        .tx_valid_i     (tx_valid_i),
        .tx_busy_o      (tx_busy_o),
        .tx_o           (tx_o),
        .rx_i           (rx_i),
        .rx_data_o      (rx_data_o),
        .rx_valid_o     (rx_valid_o),
        .rx_par_err_o   (rx_par_err_o),
        .stat_par_err_o (stat_par_err_o),
        .cmd_rst_stat_i (cmd_rst_stat_i)
    );

    function automatic logic ref_par(input logic [2:0] m, input logic [7:0] v);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(v[i]);
        case (m[1:0])
            2'b00:   return (ones % 2) == 1;
            2'b01:   return (ones % 2) == 0;
            2'b10:   return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Send one character and check every bit at its centre.
    task automatic tx_frame(input logic [7:0] v, input logic [2:0] m,
                            input logic [2:0] m_after, input bit poke,
                            input string req);
        mode_i = m;
        @(negedge clk);
        tx_data_i  = v;
        tx_valid_i = 1'b1;
        @(negedge clk);
        tx_valid_i = 1'b0;
        mode_i     = m_after;
        repeat (BIT / 2 - 1) @(negedge clk);
        check({"R1 start ", req}, int'(tx_o), 0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            tx_valid_i = 1'b0;
            repeat (BIT - 1) @(negedge clk);
            check({"R1 data ", req}, int'(tx_o), int'(v[i]));
            if (poke && i == 3) begin
                tx_data_i  = ~v;
                tx_valid_i = 1'b1;
            end
        end
        if (!m[2]) begin
            repeat (BIT) @(negedge clk);
            check({"parity ", req}, int'(tx_o), int'(ref_par(m, v)));
        end
        repeat (BIT) @(negedge clk);
        check({"R1 stop ", req}, int'(tx_o), 1);
        repeat (BIT / 2 + 1) @(negedge clk);
        check({"R1 idle busy ", req}, int'(tx_busy_o), 0);
        if (poke) begin
            repeat (2 * BIT) @(negedge clk);
            check("R11 no second frame busy", int'(tx_busy_o), 0);
            check("R11 no second frame line", int'(tx_o), 1);
        end
        mode_i = m;
    endtask

    // Drive one character into the receiver and check what it reports.
    task automatic rx_frame(input logic [7:0] v, input logic [2:0] m,
                            input logic [2:0] m_after, input bit send_par,
                            input logic pbit, input bit exp_err,
                            input bit exp_stat, input bit clr_same,
                            input string req);
        bit got = 1'b0;
        mode_i = m;
        @(negedge clk);
        rx_i = 1'b0;
        repeat (BIT) @(negedge clk);
        mode_i = m_after;
        for (int i = 0; i < 8; i++) begin
            rx_i = v[i];
            repeat (BIT) @(negedge clk);
        end
        if (send_par) begin
            rx_i = pbit;
            repeat (BIT) @(negedge clk);
        end
        rx_i = 1'b1;
        for (int k = 0; k < BIT && !got; k++) begin
            @(negedge clk);
            if (rx_valid_o) got = 1'b1;
        end
        check({"R10 delivered ", req}, int'(got), 1);
        if (got) begin
            check({"R10 data ", req}, int'(rx_data_o), int'(v));
            check({"error bit ", req}, int'(rx_par_err_o), int'(exp_err));
            if (clr_same) cmd_rst_stat_i = 1'b1;
            @(negedge clk);
            cmd_rst_stat_i = 1'b0;
            check({"R7 status ", req}, int'(stat_par_err_o), int'(exp_stat));
        end
        repeat (BIT) @(negedge clk);
        mode_i = m;
    endtask

    task automatic clear_status(input string req);
        @(negedge clk);
        cmd_rst_stat_i = 1'b1;
        @(negedge clk);
        cmd_rst_stat_i = 1'b0;
        check({"R7 cleared ", req}, int'(stat_par_err_o), 0);
    endtask

    task automatic reset_check();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R12 tx line", int'(tx_o), 1);
        check("R12 busy", int'(tx_busy_o), 0);
        check("R12 rx valid", int'(rx_valid_o), 0);
        check("R12 status", int'(stat_par_err_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        reset_check();

        // Transmit, each rule
        tx_frame(8'h41, M_EVEN,  M_EVEN,  1'b0, "R2 even 0x41");
        tx_frame(8'h41, M_ODD,   M_ODD,   1'b0, "R3 odd 0x41");
        tx_frame(8'h41, M_MARK,  M_MARK,  1'b0, "R4 mark 0x41");
        tx_frame(8'h41, M_SPACE, M_SPACE, 1'b0, "R5 space 0x41");
        tx_frame(8'h41, M_NONE,  M_NONE,  1'b0, "R6 none 0x41");
        tx_frame(8'hA7, M_EVEN,  M_EVEN,  1'b0, "R2 even 0xA7");
        tx_frame(8'h00, M_ODD,   M_ODD,   1'b0, "R3 odd 0x00");
        tx_frame(8'hFE, M_MARK,  M_MARK,  1'b0, "R4 mark 0xFE");
        // Mode changes mid-frame
        tx_frame(8'h41, M_EVEN,  M_ODD,   1'b0, "R9 tx even kept");
        tx_frame(8'h5A, M_NONE,  M_MARK,  1'b0, "R9 tx none kept");
        // Strobe while busy
        tx_frame(8'h3C, M_ODD,   M_ODD,   1'b1, "R11 busy strobe");

        // Receive, correct parity
        rx_frame(8'h41, M_EVEN,  M_EVEN,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R2 rx even ok");
        rx_frame(8'h41, M_ODD,   M_ODD,   1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R3 rx odd ok");
        rx_frame(8'h41, M_MARK,  M_MARK,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4 rx mark ok");
        rx_frame(8'h41, M_SPACE, M_SPACE, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5 rx space ok");
        rx_frame(8'hC3, M_NONE,  M_NONE,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 rx none");
        rx_frame(8'hA7, M_EVEN,  M_EVEN,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R2 rx even 0xA7");

        // Errors and the sticky flag
        rx_frame(8'h41, M_EVEN,  M_EVEN,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R2 rx even bad");
        rx_frame(8'h41, M_ODD,   M_ODD,   1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R7 held over good frame");
        clear_status("R7 after even");
        rx_frame(8'h81, M_ODD,   M_ODD,   1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R3 rx odd bad");
        clear_status("R7 after odd");
        rx_frame(8'h41, M_MARK,  M_MARK,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R4 rx mark bad");
        clear_status("R7 after mark");
        rx_frame(8'h41, M_SPACE, M_SPACE, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R5 rx space bad");
        clear_status("R7 after space");

        // Mode changes mid-frame on the receive side
        rx_frame(8'h41, M_EVEN,  M_NONE,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R9 rx even kept");
        clear_status("R7 after R9");
        rx_frame(8'h66, M_NONE,  M_EVEN,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 rx none kept");

        // Error and clear in the same cycle
        rx_frame(8'h41, M_EVEN,  M_EVEN,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R8 set beats clear");
        clear_status("R7 after R8");

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule